// File: doc/BRIEF.md
# Base Address Window Decoder

This block holds a small bank of base address registers, each describing one address window that a device claims. A setup port gives each slot a kind and a size. The kind is I/O, 32-bit memory, or 64-bit memory; a 64-bit window borrows the following slot as its upper half. Memory windows may also be marked prefetchable. The size is rounded up to a power of two, which sets the window's aperture and the bits of the base that the host may program. Host dword writes then place each window in the address map, and a read port returns any slot's current value together with its fixed type bits.

A lookup port takes an address and a flag that says whether the access is I/O or memory. It walks the slots in ascending order. Slots whose writable mask is zero are skipped, a 64-bit window takes two slots at once, and only windows of the matching kind are compared. The first window that matches wins. One cycle after the request, the block reports a hit flag, the slot index of that window and the address offset inside it. Two space-enable inputs can shut off all I/O hits or all memory hits.

Top module: `bar_decoder`

## Requirements
- R1: After reset every slot reads 0, `cfg_reject` and `res_valid` are low, and no lookup hits.
- R2: A setup with size S builds an aperture mask A = 2^ceil(log2 S) − 1, with A = 0 when S ≤ 1. It clears the slot's base and sets its writable mask and type bits by kind (`cfg_kind` encoding: 0 none, 1 I/O, 2 32-bit memory, 3 64-bit memory).
  - I/O: writable mask is 0xFFFFFFFC & ~A, and the slot reads 0x1.
  - Memory: writable mask is 0xFFFFFFF0 & ~A. Bit 2 reads 1 for a 64-bit window, and bit 3 reads 1 when `cfg_prefetch` is set.
- R3: A 64-bit setup at slot k also sets slot k+1 to read 0, with writable mask ~A[63:32].
- R4: A setup whose index is 6 or more, or a 64-bit setup at the last slot (5), raises `cfg_reject` in the next cycle and changes no slot.
- R5: A host write to slot k replaces only the bits set in that slot's writable mask; every other bit keeps its value. A host write to an index of 6 or more changes nothing.
- R6: Lookup hit rule. A window matches when (address XOR base) AND mask is zero. The mask is 64 bits wide for a 64-bit window; for a 32-bit window the upper 32 bits of the mask are zero. I/O lookups consider only I/O windows, and memory lookups consider only memory windows.
- R7: Slots are scanned in ascending order. The upper slot of a 64-bit window is never matched on its own, slots with a zero mask are skipped, and the lowest-indexed match is reported.
- R8: On a hit, `res_offset` equals the address AND NOT the window's mask. For a 32-bit window this keeps all upper address bits. On a miss, `res_offset` and `res_index` are 0.
- R9: An I/O lookup never hits while `io_space_en` is low, and a memory lookup never hits while `mem_space_en` is low.
- R10: `res_valid` is high exactly in the cycle after a cycle with `lk_valid` high, and `res_hit` is never high without `res_valid`.
- R11: A setup of kind 0 makes the slot read 0 with a zero mask, so that slot is skipped by lookups and ignores host writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Setup request strobe |
| cfg_index | input | 3 | Slot to set up |
| cfg_kind | input | 2 | Window kind (0 none, 1 I/O, 2 mem32, 3 mem64) |
| cfg_prefetch | input | 1 | Mark memory window prefetchable |
| cfg_size | input | 64 | Window size in bytes |
| cfg_reject | output | 1 | Previous setup request was illegal |
| hw_valid | input | 1 | Host dword write strobe |
| hw_index | input | 3 | Slot written by host |
| hw_data | input | 32 | Host write data |
| rd_index | input | 3 | Slot to read back |
| rd_data | output | 32 | Current slot value (0 for out-of-range index) |
| io_space_en | input | 1 | Allow I/O hits |
| mem_space_en | input | 1 | Allow memory hits |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 64 | Lookup address |
| lk_is_io | input | 1 | Lookup is an I/O access |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Lookup matched a window |
| res_index | output | 3 | Index of the matched slot |
| res_offset | output | 64 | Address offset inside the matched window |

## Verification
The hardest case to reach from the ports is a 64-bit window whose upper slot would also match as a 32-bit window if it were scanned on its own. The base programmed into the upper slot has to line up with an address that the lower half rejects. The bench places a 64-bit window at a nonzero upper base, so its upper slot holds a nonzero value under a full mask, and then sweeps addresses whose low dword equals that value. Only the pairing rule keeps those addresses from hitting. The sweep also covers both window edges and the first byte past each window, for both access kinds. Overlapping windows are included to check the first-match order, and the shadowing window is later disabled to show the next one taking over.

// File: rtl/bar_dec_pkg.sv
`timescale 1ns/1ps
package bar_dec_pkg;
    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_IO    = 2'd1,
        KIND_MEM32 = 2'd2,
        KIND_MEM64 = 2'd3
    } bar_kind_e;

    localparam logic [31:0] IO_FLOOR  = 32'hFFFF_FFFC;
    localparam logic [31:0] MEM_FLOOR = 32'hFFFF_FFF0;
    localparam logic [31:0] TYPE_IO   = 32'h0000_0001;
    localparam logic [31:0] TYPE_W64  = 32'h0000_0004;
    localparam logic [31:0] TYPE_PF   = 32'h0000_0008;
endpackage

// File: rtl/bar_size_mask.sv
`timescale 1ns/1ps
// Rounds a byte count up to a power of two and returns that size minus one.
module bar_size_mask #(
    parameter int SIZE_W = 64
) (
    input  logic [SIZE_W-1:0] size,
    output logic [SIZE_W-1:0] mask
);
    logic [SIZE_W-1:0] less_one;
    logic [SIZE_W-1:0] smear;

    assign less_one = size - 1'b1;

    // every bit at or below the top set bit of (size-1) becomes one
    for (genvar g = 0; g < SIZE_W; g++) begin : g_smear
        assign smear[g] = |less_one[SIZE_W-1:g];
    end

    assign mask = (size == '0) ? '0 : smear;
endmodule

// File: rtl/bar_hit_scan.sv
`timescale 1ns/1ps
// Ordered first-match scan over the window slots.
module bar_hit_scan #(
    parameter int NUM_BARS = 6,
    parameter int IDX_W    = 3
) (
    input  logic [NUM_BARS-1:0][31:0] slot_val,
    input  logic [NUM_BARS-1:0][31:0] slot_msk,
    input  logic [63:0]               addr,
    input  logic                      is_io,
    input  logic                      io_en,
    input  logic                      mem_en,
    output logic                      hit,
    output logic [IDX_W-1:0]          idx,
    output logic [63:0]               offset
);
    logic [63:0] wide_v;
    logic [63:0] wide_m;
    logic        skip;
    logic        match;

    always_comb begin
        hit    = 1'b0;
        idx    = '0;
        offset = '0;
        skip   = 1'b0;
        wide_v = '0;
        wide_m = '0;
        match  = 1'b0;
        for (int i = 0; i < NUM_BARS; i++) begin
            wide_v = {32'b0, slot_val[i]};
            wide_m = {32'b0, slot_msk[i]};
            match  = 1'b0;
            if (skip) begin
                skip = 1'b0;
            end else if (slot_msk[i] != '0) begin
                if (slot_val[i][0]) begin
                    match = is_io && io_en;
                end else begin
                    if (slot_val[i][2] && (i + 1 < NUM_BARS)) begin
                        wide_v[63:32] = slot_val[(i + 1) % NUM_BARS];
                        wide_m[63:32] = slot_msk[(i + 1) % NUM_BARS];
                        skip          = 1'b1;
                    end
                    match = !is_io && mem_en;
                end
                if (match && !hit && (((addr ^ wide_v) & wide_m) == '0)) begin
                    hit    = 1'b1;
                    idx    = IDX_W'(i);
                    offset = addr & ~wide_m;
                end
            end
        end
    end
endmodule

// File: rtl/bar_decoder.sv
`timescale 1ns/1ps
module bar_decoder #(
    parameter int NUM_BARS = 6,
    parameter int IDX_W    = $clog2(NUM_BARS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [IDX_W-1:0]  cfg_index,
    input  logic [1:0]        cfg_kind,
    input  logic              cfg_prefetch,
    input  logic [63:0]       cfg_size,
    output logic              cfg_reject,
    input  logic              hw_valid,
    input  logic [IDX_W-1:0]  hw_index,
    input  logic [31:0]       hw_data,
    input  logic [IDX_W-1:0]  rd_index,
    output logic [31:0]       rd_data,
    input  logic              io_space_en,
    input  logic              mem_space_en,
    input  logic              lk_valid,
    input  logic [63:0]       lk_addr,
    input  logic              lk_is_io,
    output logic              res_valid,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_index,
    output logic [63:0]       res_offset
);
    import bar_dec_pkg::*;

    localparam logic [IDX_W:0] SLOT_LIMIT = (IDX_W+1)'(NUM_BARS);
    localparam logic [IDX_W:0] LAST_SLOT  = (IDX_W+1)'(NUM_BARS - 1);

    typedef struct packed {
        logic [NUM_BARS-1:0][31:0] val;
        logic [NUM_BARS-1:0][31:0] msk;
        logic                      rej;
        logic                      rv;
        logic                      rh;
        logic [IDX_W-1:0]          ridx;
        logic [63:0]               roff;
    } state_t;

    state_t st_d, st_q;

    logic [63:0]      aperture;
    logic             scan_hit;
    logic [IDX_W-1:0] scan_idx;
    logic [63:0]      scan_off;
    logic             cfg_bad;
    logic [IDX_W-1:0] next_idx;
    logic [31:0]      pf_bits;

    bar_size_mask #(.SIZE_W(64)) u_size (
        .size (cfg_size),
        .mask (aperture)
    );

    bar_hit_scan #(.NUM_BARS(NUM_BARS), .IDX_W(IDX_W)) u_scan (
        .slot_val (st_q.val),
        .slot_msk (st_q.msk),
        .addr     (lk_addr),
        .is_io    (lk_is_io),
        .io_en    (io_space_en),
        .mem_en   (mem_space_en),
        .hit      (scan_hit),
        .idx      (scan_idx),
        .offset   (scan_off)
    );

    assign next_idx = cfg_index + 1'b1;
    assign pf_bits  = cfg_prefetch ? TYPE_PF : 32'h0;
    assign cfg_bad  = ({1'b0, cfg_index} >= SLOT_LIMIT) ||
                      ((bar_kind_e'(cfg_kind) == KIND_MEM64) && ({1'b0, cfg_index} == LAST_SLOT));

    always_comb begin
        st_d     = st_q;
        st_d.rej = 1'b0;

        // host placement of a window: only mask bits move
        if (hw_valid && ({1'b0, hw_index} < SLOT_LIMIT)) begin
            st_d.val[hw_index] = (st_q.val[hw_index] & ~st_q.msk[hw_index]) |
                                 (hw_data & st_q.msk[hw_index]);
        end

        // setup takes precedence over a host write in the same cycle
        if (cfg_valid) begin
            if (cfg_bad) begin
                st_d.rej = 1'b1;
            end else begin
                case (bar_kind_e'(cfg_kind))
                    KIND_IO: begin
                        st_d.val[cfg_index] = TYPE_IO;
                        st_d.msk[cfg_index] = IO_FLOOR & ~aperture[31:0];
                    end
                    KIND_MEM32: begin
                        st_d.val[cfg_index] = pf_bits;
                        st_d.msk[cfg_index] = MEM_FLOOR & ~aperture[31:0];
                    end
                    KIND_MEM64: begin
                        st_d.val[cfg_index] = TYPE_W64 | pf_bits;
                        st_d.msk[cfg_index] = MEM_FLOOR & ~aperture[31:0];
                        st_d.val[next_idx]  = 32'h0;
                        st_d.msk[next_idx]  = ~aperture[63:32];
                    end
                    default: begin
                        st_d.val[cfg_index] = 32'h0;
                        st_d.msk[cfg_index] = 32'h0;
                    end
                endcase
            end
        end

        st_d.rv   = lk_valid;
        st_d.rh   = lk_valid && scan_hit;
        st_d.ridx = (lk_valid && scan_hit) ? scan_idx : '0;
        st_d.roff = (lk_valid && scan_hit) ? scan_off : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data    = ({1'b0, rd_index} < SLOT_LIMIT) ? st_q.val[rd_index] : 32'h0;
    assign cfg_reject = st_q.rej;
    assign res_valid  = st_q.rv;
    assign res_hit    = st_q.rh;
    assign res_index  = st_q.ridx;
    assign res_offset = st_q.roff;
endmodule

// File: rtl/bar_decoder_chk.sv
`timescale 1ns/1ps
module bar_decoder_chk #(
    parameter int NUM_BARS = 6,
    parameter int IDX_W    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_valid,
    input logic [IDX_W-1:0] cfg_index,
    input logic [1:0]       cfg_kind,
    input logic             cfg_reject,
    input logic             lk_valid,
    input logic             lk_is_io,
    input logic             io_space_en,
    input logic             mem_space_en,
    input logic             res_valid,
    input logic             res_hit,
    input logic [IDX_W-1:0] res_index
);
    localparam logic [IDX_W:0] SLOT_LIMIT = (IDX_W+1)'(NUM_BARS);
    localparam logic [IDX_W:0] LAST_SLOT  = (IDX_W+1)'(NUM_BARS - 1);

    assert_hit_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid);

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    assert_io_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_is_io && !io_space_en) |=> !res_hit);

    assert_mem_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_is_io && !mem_space_en) |=> !res_hit);

    assert_reject_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && ({1'b0, cfg_index} >= SLOT_LIMIT)) |=> cfg_reject);

    assert_reject_last_wide_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && ({1'b0, cfg_index} == LAST_SLOT) && (cfg_kind == 2'd3)) |=> cfg_reject);

    assert_index_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> ({1'b0, res_index} < SLOT_LIMIT));
endmodule

bind bar_decoder bar_decoder_chk #(.NUM_BARS(NUM_BARS), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/bar_decoder_bench.sv
`timescale 1ns/1ps
module bar_decoder_bench;
    localparam int NB = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_valid;
    logic [2:0]  cfg_index;
    logic [1:0]  cfg_kind;
    logic        cfg_prefetch;
    logic [63:0] cfg_size;
    logic        cfg_reject;
    logic        hw_valid;
    logic [2:0]  hw_index;
    logic [31:0] hw_data;
    logic [2:0]  rd_index;
    logic [31:0] rd_data;
    logic        io_space_en;
    logic        mem_space_en;
    logic        lk_valid;
    logic [63:0] lk_addr;
    logic        lk_is_io;
    logic        res_valid;
    logic        res_hit;
    logic [2:0]  res_index;
    logic [63:0] res_offset;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    logic [31:0] m_val [NB];
    logic [31:0] m_msk [NB];

    always #4 clk = ~clk;

    bar_decoder u_bar_decoder (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pow2mask(input logic [63:0] s);
        int k;
        if (s <= 64'd1) return 64'd0;
        k = 0;
        while ((64'd1 << k) < s) k++;
        return (64'd1 << k) - 64'd1;
    endfunction

    task automatic model_lookup(input logic [63:0] a, input logic io,
                                output logic h, output logic [2:0] ix, output logic [63:0] off);
        int i;
        int cur;
        logic [63:0] wv, wm;
        logic ok;
        h = 0; ix = 0; off = 0; i = 0;
        while (i < NB) begin
            cur = i;
            i++;
            if (m_msk[cur] == 32'h0) continue;
            wv = {32'h0, m_val[cur]};
            wm = {32'h0, m_msk[cur]};
            if (m_val[cur][0]) begin
                ok = io && io_space_en;
            end else begin
                if (m_val[cur][2] && i < NB) begin
                    wv[63:32] = m_val[i];
                    wm[63:32] = m_msk[i];
                    i++;
                end
                ok = !io && mem_space_en;
            end
            if (ok && !h && (((a ^ wv) & wm) == 64'h0)) begin
                h = 1; ix = 3'(cur); off = a & ~wm;
            end
        end
    endtask

    task automatic check_reads(input string req);
        for (int i = 0; i < 8; i++) begin
            rd_index = 3'(i);
            #1;
            check(req, {32'h0, rd_data}, (i < NB) ? {32'h0, m_val[i]} : 64'h0);
        end
    endtask

    task automatic do_cfg(input int idx, input logic [1:0] kind, input logic pf, input logic [63:0] size);
        logic bad;
        logic [63:0] a;
        bad = (idx >= NB) || (kind == 2'd3 && idx == NB - 1);
        @(negedge clk);
        cfg_valid = 1; cfg_index = 3'(idx); cfg_kind = kind; cfg_prefetch = pf; cfg_size = size;
        @(posedge clk);
        @(negedge clk);
        cfg_valid = 0;
        check("R4 reject flag", {63'h0, cfg_reject}, {63'h0, bad});
        if (!bad) begin
            a = pow2mask(size);
            case (kind)
                2'd1: begin m_val[idx] = 32'h1; m_msk[idx] = 32'hFFFF_FFFC & ~a[31:0]; end
                2'd2: begin m_val[idx] = pf ? 32'h8 : 32'h0; m_msk[idx] = 32'hFFFF_FFF0 & ~a[31:0]; end
                2'd3: begin
                    m_val[idx] = 32'h4 | (pf ? 32'h8 : 32'h0);
                    m_msk[idx] = 32'hFFFF_FFF0 & ~a[31:0];
                    m_val[idx+1] = 32'h0;
                    m_msk[idx+1] = ~a[63:32];
                end
                default: begin m_val[idx] = 32'h0; m_msk[idx] = 32'h0; end
            endcase
        end
    endtask

    task automatic do_hw(input int idx, input logic [31:0] d);
        @(negedge clk);
        hw_valid = 1; hw_index = 3'(idx); hw_data = d;
        @(posedge clk);
        @(negedge clk);
        hw_valid = 0;
        if (idx < NB) m_val[idx] = (m_val[idx] & ~m_msk[idx]) | (d & m_msk[idx]);
    endtask

    task automatic do_lk(input logic [63:0] a, input logic io, input string req);
        logic h;
        logic [2:0] ix;
        logic [63:0] off;
        model_lookup(a, io, h, ix, off);
        @(negedge clk);
        lk_valid = 1; lk_addr = a; lk_is_io = io;
        @(posedge clk);
        @(negedge clk);
        lk_valid = 0;
        check({req, " R10 valid"}, {63'h0, res_valid}, 64'h1);
        check({req, " hit"}, {63'h0, res_hit}, {63'h0, h});
        check({req, " R7 index"}, {61'h0, res_index}, {61'h0, ix});
        check({req, " R8 offset"}, res_offset, off);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] pts [$];
        logic [63:0] bases [4];
        logic [63:0] sizes [4];

        for (int i = 0; i < NB; i++) begin m_val[i] = 0; m_msk[i] = 0; end
        rst_n = 0; cfg_valid = 0; cfg_index = 0; cfg_kind = 0; cfg_prefetch = 0; cfg_size = 0;
        hw_valid = 0; hw_index = 0; hw_data = 0; rd_index = 0;
        io_space_en = 1; mem_space_en = 1; lk_valid = 0; lk_addr = 0; lk_is_io = 0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1 reset state
        check("R1 res_valid", {63'h0, res_valid}, 64'h0);
        check("R1 cfg_reject", {63'h0, cfg_reject}, 64'h0);
        check_reads("R1 readback");
        do_lk(64'h0, 0, "R1 mem");
        do_lk(64'h0, 1, "R1 io");

        // R2 R3 setup of every kind
        do_cfg(0, 2'd1, 0, 64'd16);
        do_cfg(1, 2'd2, 1, 64'd4096);
        do_cfg(2, 2'd3, 0, 64'd1 << 20);
        do_cfg(4, 2'd2, 0, 64'd100);
        do_cfg(5, 2'd0, 0, 64'd64);
        check_reads("R2 R3 type bits");

        // R5 host writes expose writable masks
        for (int i = 0; i < NB; i++) do_hw(i, 32'hFFFF_FFFF);
        check_reads("R5 mask readback");
        do_hw(7, 32'h1234_5678);
        check_reads("R5 out of range write");

        // place the windows
        do_hw(0, 32'h0000_1000);
        do_hw(1, 32'h8000_0000);
        do_hw(2, 32'h0030_0000);
        do_hw(3, 32'h0000_0001);
        do_hw(4, 32'h4000_0080);
        check_reads("R5 placed");

        // R4 illegal setups leave state alone
        do_cfg(6, 2'd2, 0, 64'd16);
        do_cfg(7, 2'd1, 0, 64'd16);
        do_cfg(5, 2'd3, 0, 64'd16);
        check_reads("R4 unchanged");

        // R6 R7 R8 sweep of edges for both access kinds
        bases[0] = 64'h1000;        sizes[0] = 64'd16;
        bases[1] = 64'h8000_0000;   sizes[1] = 64'd4096;
        bases[2] = 64'h1_0030_0000; sizes[2] = 64'd1 << 20;
        bases[3] = 64'h4000_0080;   sizes[3] = 64'd128;
        for (int b = 0; b < 4; b++) begin
            pts.push_back(bases[b]);
            pts.push_back(bases[b] + sizes[b] - 1);
            pts.push_back(bases[b] + sizes[b]);
            pts.push_back(bases[b] - 1);
        end
        pts.push_back(64'h0);
        pts.push_back(64'h1);
        pts.push_back(64'h1_0000_0000);
        pts.push_back(64'hF_8000_0010);
        pts.push_back(64'h2_0030_0000);
        foreach (pts[p]) begin
            do_lk(pts[p], 0, "R6 mem sweep");
            do_lk(pts[p], 1, "R6 io sweep");
        end

        // R7 overlap: lower index wins
        do_hw(4, 32'h8000_0000);
        do_lk(64'h8000_0010, 0, "R7 overlap");
        // R11 remove the shadowing window
        do_cfg(1, 2'd0, 0, 64'd4096);
        check_reads("R11 cleared");
        do_hw(1, 32'hFFFF_FFFF);
        check_reads("R11 write ignored");
        do_lk(64'h8000_0010, 0, "R11 fallthrough");

        // R9 space enables
        io_space_en = 0;
        do_lk(64'h1004, 1, "R9 io off");
        io_space_en = 1;
        mem_space_en = 0;
        do_lk(64'h1_0030_0010, 0, "R9 mem off");
        mem_space_en = 1;
        do_lk(64'h1004, 1, "R9 io on");

        // R2 size rounding sweep on two kinds
        for (int k = 0; k < 14; k++) begin
            do_cfg(4, 2'd2, k[0], (64'd1 << k) + 64'(k % 3));
            do_hw(4, 32'hFFFF_FFFF);
            rd_index = 3'd4;
            #1;
            check("R2 mem rounding", {32'h0, rd_data}, {32'h0, m_val[4]});
            do_cfg(0, 2'd1, 0, (64'd1 << k) - 64'(k % 2));
            do_hw(0, 32'hFFFF_FFFF);
            rd_index = 3'd0;
            #1;
            check("R2 io rounding", {32'h0, rd_data}, {32'h0, m_val[0]});
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule